// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

This block is a small register window that lets a host processor hand work to an on-chip management controller and collect the answer. The host fills a payload buffer and then writes one command word. That write marks the mailbox busy and sends a one-cycle doorbell pulse to the controller. The controller reads the latched command word and the payload words through its own port. It loads a response buffer and then posts completion with a one-cycle done strobe, together with an error flag and an 8-bit error code.

Completion clears busy and stores the error fields in the status word. If the command asked for it, completion also sends a one-cycle completion pulse back to the host. The host polls the status word or waits for that pulse, then reads the response as whole words or as single bytes. A command word written while the mailbox is still busy is discarded, and a sticky flag records the event.

The window spans 256 bytes. Command sits at 0x00, status at 0x04, the payload buffer at 0x80 to 0x8F and the response buffer at 0x90 to 0x9F.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset, busy, error, the error code and the overrun flag are 0, no interrupt pulse is active, and a status read at 0x04 returns 0.
- R2: A host write to offset 0x00 while idle sets busy and raises `ctl_doorbell` for exactly the following cycle. The same write latches the word on `ctl_cmd`, whose fields are opcode [7:0], completion-pulse request [8], sub-command [15:12] and payload size [23:16]. The status word then shows busy in bit 0, the sub-command in bits [7:4] and the `host_src_id` captured at that write in bits [15:8].
- R3: A host write to 0x80 + 4k stores the 32-bit word as payload word k, which the controller sees on `ctl_wbuf_rdata` when `ctl_wbuf_idx` = k.
- R4: A host word read at 0x90 + 4k returns response word k as last loaded by the controller.
- R5: A host byte read (`host_rd_byte` = 1) at 0x90 + n returns response byte n in bits [7:0] with zeros above. Byte 4k+j is bits [8j+7:8j] of word k.
- R6: Busy stays set until a `ctl_done` strobe arrives while busy. That strobe clears busy on the next cycle and latches `ctl_err` into status bit 1 and `ctl_err_code` into status bits [23:16].
- R7: `host_done_irq` is high for exactly the cycle after a done strobe that completes a command with bit 8 set, and it never fires otherwise.
- R8: A command write while busy changes neither `ctl_cmd` nor the status word and raises no doorbell. It sets `cmd_overrun`, which stays set until reset.
- R9: Host reads of 0x00, of the payload buffer and of unmapped offsets return 0. Host writes to 0x04 and to the response buffer have no effect.
- R10: An accepted command clears the stored error bit and error code.
- R11: A done strobe while idle is ignored: no completion pulse, and the status word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_byte | input | 1 | 1 = byte read, 0 = 32-bit read |
| host_addr | input | 8 | Byte offset in the window |
| host_wdata | input | 32 | Host write data |
| host_src_id | input | 8 | Initiator id captured with a command |
| host_rdata | output | 32 | Host read data (combinational, 0 when not reading) |
| host_done_irq | output | 1 | One-cycle completion pulse |
| cmd_overrun | output | 1 | Sticky flag for a command written while busy |
| ctl_doorbell | output | 1 | One-cycle doorbell pulse to the controller |
| ctl_cmd | output | 32 | Latched command word |
| ctl_wbuf_idx | input | 2 | Payload word index for the controller |
| ctl_wbuf_rdata | output | 32 | Selected payload word |
| ctl_rbuf_we | input | 1 | Response buffer write enable |
| ctl_rbuf_idx | input | 2 | Response word index |
| ctl_rbuf_wdata | input | 32 | Response word data |
| ctl_done | input | 1 | One-cycle completion strobe |
| ctl_err | input | 1 | Error flag sampled with the done strobe |
| ctl_err_code | input | 8 | Error code sampled with the done strobe |

## Verification
Commands are sent with different sub-command values, initiator ids and completion-pulse settings. A second command is written during the busy window, which tells a correctly discarded write apart from one that overwrites the in-flight command. The response buffer is filled with a distinct value in every byte. Word reads and byte reads at the first, a middle and the last offsets then show whether the index and byte-lane selection are correct. Writes to read-only offsets, reads of write-only and unmapped offsets, and a done strobe with no command pending show whether each of these is truly without effect.

// File: rtl/mbx_pkg.sv
// Shared layout of the doorbell mailbox: offsets and the packed
// command and status word formats. Assumes a 32-bit host data path.
package mbx_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam logic [7:0]  OFF_CMD  = 8'h00;
    localparam logic [7:0]  OFF_STAT = 8'h04;
    localparam logic [7:0]  OFF_WBUF = 8'h80;
    localparam logic [7:0]  OFF_RBUF = 8'h90;

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] size;
        logic [3:0] sub_id;
        logic [2:0] rsv_lo;
        logic       want_irq;
        logic [7:0] opcode;
    } cmd_word_t;

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] err_code;
        logic [7:0] init_id;
        logic [3:0] sub_id;
        logic [1:0] rsv_lo;
        logic       err;
        logic       busy;
    } stat_word_t;
endpackage

// File: rtl/mbx_cmd_status.sv
// Command latch and busy/error state machine of the mailbox.
// Accepts a command only while idle, records overruns, and turns
// the controller's done strobe into status and a completion pulse.
// Assumes done is a single-cycle strobe.
module mbx_cmd_status
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [7:0]        src_id,
    input  logic              done,
    input  logic              err_in,
    input  logic [7:0]        code_in,
    output cmd_word_t         cmd_q,
    output stat_word_t        stat,
    output logic              busy,
    output logic              doorbell,
    output logic              done_irq,
    output logic              overrun
);
    logic       err_q;
    logic [7:0] code_q;
    logic [7:0] init_q;
    logic       accept;
    logic       finish;

    assign accept = cmd_wr && !busy;
    assign finish = done && busy;

    // Latch an accepted command with its initiator id.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            init_q <= '0;
        end else if (accept) begin
            cmd_q  <= cmd_word_t'(cmd_wdata);
            init_q <= src_id;
        end
    end

    // Busy, error fields and the two interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            err_q    <= 1'b0;
            code_q   <= '0;
            doorbell <= 1'b0;
            done_irq <= 1'b0;
        end else begin
            doorbell <= accept;
            done_irq <= finish && cmd_q.want_irq;
            if (accept) begin
                busy   <= 1'b1;
                err_q  <= 1'b0;
                code_q <= '0;
            end else if (finish) begin
                busy   <= 1'b0;
                err_q  <= err_in;
                code_q <= code_in;
            end
        end
    end

    // Sticky record of a command written while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)               overrun <= 1'b0;
        else if (cmd_wr && busy)  overrun <= 1'b1;
    end

    // Assemble the status word from the stored fields.
    always_comb begin
        stat          = '0;
        stat.busy     = busy;
        stat.err      = err_q;
        stat.sub_id   = cmd_q.sub_id;
        stat.init_id  = init_q;
        stat.err_code = code_q;
    end
endmodule

// File: rtl/mbx_buffers.sv
// Payload (host-written) and response (controller-written) buffers.
// Each holds WORDS 32-bit entries; both read ports are combinational.
module mbx_buffers
    import mbx_pkg::*;
#(
    parameter int unsigned WORDS = 4,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wbuf_we,
    input  logic [IDX_W-1:0]  wbuf_widx,
    input  logic [DATA_W-1:0] wbuf_wdata,
    input  logic [IDX_W-1:0]  wbuf_ridx,
    output logic [DATA_W-1:0] wbuf_rdata,
    input  logic              rbuf_we,
    input  logic [IDX_W-1:0]  rbuf_widx,
    input  logic [DATA_W-1:0] rbuf_wdata,
    input  logic [IDX_W-1:0]  rbuf_ridx,
    output logic [DATA_W-1:0] rbuf_rdata
);
    logic [DATA_W-1:0] wmem [WORDS];
    logic [DATA_W-1:0] rmem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // One payload word and one response word per index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wmem[i] <= '0;
                rmem[i] <= '0;
            end else begin
                if (wbuf_we && wbuf_widx == IDX_W'(i)) wmem[i] <= wbuf_wdata;
                if (rbuf_we && rbuf_widx == IDX_W'(i)) rmem[i] <= rbuf_wdata;
            end
        end
    end

    assign wbuf_rdata = wmem[wbuf_ridx];
    assign rbuf_rdata = rmem[rbuf_ridx];
endmodule

// File: rtl/mbx_doorbell.sv
// Top of the doorbell mailbox: host address decode, read mux with
// byte-lane selection, and the two submodules. Read data is
// combinational and zero unless a read is strobed.
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BUF_WORDS = 4,
    localparam int unsigned IDX_W    = $clog2(BUF_WORDS),
    localparam int unsigned BUF_B    = BUF_WORDS * 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic              host_rd_byte,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    input  logic [7:0]        host_src_id,
    output logic [31:0]       host_rdata,
    output logic              host_done_irq,
    output logic              cmd_overrun,
    output logic              ctl_doorbell,
    output logic [31:0]       ctl_cmd,
    input  logic [IDX_W-1:0]  ctl_wbuf_idx,
    output logic [31:0]       ctl_wbuf_rdata,
    input  logic              ctl_rbuf_we,
    input  logic [IDX_W-1:0]  ctl_rbuf_idx,
    input  logic [31:0]       ctl_rbuf_wdata,
    input  logic              ctl_done,
    input  logic              ctl_err,
    input  logic [7:0]        ctl_err_code
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_WBUF = ADDR_W'(OFF_WBUF);
    localparam logic [ADDR_W-1:0] A_RBUF = ADDR_W'(OFF_RBUF);

    logic              hit_cmd, hit_stat, hit_wbuf, hit_rbuf;
    logic [ADDR_W-1:0] wofs, rofs;
    logic [IDX_W-1:0]  rbuf_ridx;
    logic [31:0]       rbuf_word, rbuf_byte;
    cmd_word_t         cmd_q;
    stat_word_t        stat;
    logic              busy_q;

    // Decode the host offset into one of the four regions.
    always_comb begin
        wofs     = host_addr - A_WBUF;
        rofs     = host_addr - A_RBUF;
        hit_cmd  = host_addr == A_CMD;
        hit_stat = host_addr == A_STAT;
        hit_wbuf = host_addr >= A_WBUF && wofs < ADDR_W'(BUF_B);
        hit_rbuf = host_addr >= A_RBUF && rofs < ADDR_W'(BUF_B);
    end

    assign rbuf_ridx = rofs[IDX_W+1:2];

    mbx_cmd_status u_cs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (host_wr_en && hit_cmd),
        .cmd_wdata (host_wdata),
        .src_id    (host_src_id),
        .done      (ctl_done),
        .err_in    (ctl_err),
        .code_in   (ctl_err_code),
        .cmd_q     (cmd_q),
        .stat      (stat),
        .busy      (busy_q),
        .doorbell  (ctl_doorbell),
        .done_irq  (host_done_irq),
        .overrun   (cmd_overrun)
    );

    mbx_buffers #(.WORDS(BUF_WORDS)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wbuf_we    (host_wr_en && hit_wbuf),
        .wbuf_widx  (wofs[IDX_W+1:2]),
        .wbuf_wdata (host_wdata),
        .wbuf_ridx  (ctl_wbuf_idx),
        .wbuf_rdata (ctl_wbuf_rdata),
        .rbuf_we    (ctl_rbuf_we),
        .rbuf_widx  (ctl_rbuf_idx),
        .rbuf_wdata (ctl_rbuf_wdata),
        .rbuf_ridx  (rbuf_ridx),
        .rbuf_rdata (rbuf_word)
    );

    assign ctl_cmd   = cmd_q;
    assign rbuf_byte = {24'h0, 8'(rbuf_word >> {rofs[1:0], 3'b000})};

    // Host read mux: status, response buffer, zero elsewhere.
    always_comb begin
        host_rdata = '0;
        if (host_rd_en) begin
            if (hit_stat && !host_rd_byte) host_rdata = stat;
            else if (hit_rbuf)             host_rdata = host_rd_byte ? rbuf_byte : rbuf_word;
        end
    end
endmodule

// File: rtl/mbx_doorbell_checker.sv
// Protocol checks for mbx_doorbell, attached with bind below.
module mbx_doorbell_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr_en,
    input logic [7:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic        busy,
    input logic        ctl_done,
    input logic [31:0] ctl_cmd,
    input logic        ctl_doorbell,
    input logic        host_done_irq,
    input logic        cmd_overrun
);
    logic wr_cmd;
    assign wr_cmd = host_wr_en && host_addr == 8'h00;

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd && !busy |=> busy && ctl_doorbell && ctl_cmd == $past(host_wdata));
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |=> !ctl_doorbell);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ctl_done |=> busy);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ctl_done |=> !busy);
    assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ctl_done && ctl_cmd[8] |=> host_done_irq);
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_done_irq |-> $past(busy && ctl_done && ctl_cmd[8]));
    assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd && busy |=> cmd_overrun && $stable(ctl_cmd) && !ctl_doorbell);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_overrun |=> cmd_overrun);
    assert_idle_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && ctl_done |=> !host_done_irq);
endmodule

bind mbx_doorbell mbx_doorbell_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr_en    (host_wr_en),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .busy          (busy_q),
    .ctl_done      (ctl_done),
    .ctl_cmd       (ctl_cmd),
    .ctl_doorbell  (ctl_doorbell),
    .host_done_irq (host_done_irq),
    .cmd_overrun   (cmd_overrun)
);

// File: tb/mbx_doorbell_test.sv
// Scoreboard bench: read tasks queue expected values, a monitor
// pops and compares them mid-cycle; other outputs checked directly.
module mbx_doorbell_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0, host_rd_en = 1'b0, host_rd_byte = 1'b0;
    logic [7:0]  host_addr = '0, host_src_id = '0, ctl_err_code = '0;
    logic [31:0] host_wdata = '0, ctl_rbuf_wdata = '0;
    logic [31:0] host_rdata, ctl_cmd, ctl_wbuf_rdata;
    logic        host_done_irq, cmd_overrun, ctl_doorbell;
    logic [1:0]  ctl_wbuf_idx = '0, ctl_rbuf_idx = '0;
    logic        ctl_rbuf_we = 1'b0, ctl_done = 1'b0, ctl_err = 1'b0;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    mbx_doorbell uut (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, input logic bytewise,
                           input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_rd_en = 1'b1; host_rd_byte = bytewise; host_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_rd_en = 1'b0; host_rd_byte = 1'b0;
    endtask

    task automatic ctl_load(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        ctl_rbuf_we = 1'b1; ctl_rbuf_idx = i; ctl_rbuf_wdata = d;
        @(negedge clk);
        ctl_rbuf_we = 1'b0;
    endtask

    task automatic ctl_finish(input logic e, input logic [7:0] c);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = c;
        @(negedge clk);
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
    endtask

    // Monitor: compare each queued read mid-cycle.
    initial begin
        forever begin
            @(posedge clk); #2;
            if (host_rd_en && exp_q.size() > 0)
                check(host_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check({29'h0, ctl_doorbell, host_done_irq, cmd_overrun}, 32'h0, "R1 outputs");
        host_rd(8'h04, 1'b0, 32'h0, "R1 status");

        // R3 payload words
        for (int k = 0; k < 4; k++) host_wr(8'h80 + 8'(4*k), 32'hA0B0C000 + 32'(k));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ctl_wbuf_idx = 2'(k); #1;
            check(ctl_wbuf_rdata, 32'hA0B0C000 + 32'(k), "R3 payload");
        end
        host_rd(8'h84, 1'b0, 32'h0, "R9 payload read");

        // R2 accept a command with completion pulse requested
        host_src_id = 8'h5A;
        host_wr(8'h00, 32'h000C31A5);
        check({31'h0, ctl_doorbell}, 32'h1, "R2 doorbell");
        check(ctl_cmd, 32'h000C31A5, "R2 cmd");
        @(negedge clk);
        check({31'h0, ctl_doorbell}, 32'h0, "R2 single pulse");
        host_rd(8'h04, 1'b0, 32'h00005A31, "R2 status");
        host_rd(8'h00, 1'b0, 32'h0, "R9 cmd read");

        // R8 command while busy
        host_src_id = 8'h22;
        host_wr(8'h00, 32'h00000BEE);
        check({31'h0, ctl_doorbell}, 32'h0, "R8 no doorbell");
        check(ctl_cmd, 32'h000C31A5, "R8 cmd kept");
        check({31'h0, cmd_overrun}, 32'h1, "R8 overrun");
        host_rd(8'h04, 1'b0, 32'h00005A31, "R8 status kept");

        // R6/R7 response and completion with error
        ctl_load(2'd0, 32'h44332211);
        ctl_load(2'd1, 32'h88776655);
        ctl_load(2'd2, 32'hCCBBAA99);
        ctl_load(2'd3, 32'h00FFEEDD);
        host_rd(8'h04, 1'b0, 32'h00005A31, "R6 busy held");
        ctl_finish(1'b1, 8'h7E);
        check({31'h0, host_done_irq}, 32'h1, "R7 done irq");
        @(negedge clk);
        check({31'h0, host_done_irq}, 32'h0, "R7 single pulse");
        host_rd(8'h04, 1'b0, 32'h007E5A32, "R6 status");

        // R4/R5 reads
        host_rd(8'h94, 1'b0, 32'h88776655, "R4 word1");
        host_rd(8'h9C, 1'b0, 32'h00FFEEDD, "R4 word3");
        host_rd(8'h90, 1'b1, 32'h00000011, "R5 byte0");
        host_rd(8'h97, 1'b1, 32'h00000088, "R5 byte7");
        host_rd(8'h9E, 1'b1, 32'h000000FF, "R5 byte14");
        host_rd(8'h9F, 1'b1, 32'h00000000, "R5 byte15");

        // R9 read-only writes and unmapped reads
        host_wr(8'h04, 32'hFFFFFFFF);
        host_wr(8'h98, 32'h12345678);
        host_rd(8'h04, 1'b0, 32'h007E5A32, "R9 status write");
        host_rd(8'h98, 1'b0, 32'hCCBBAA99, "R9 rbuf write");
        host_rd(8'h40, 1'b0, 32'h0, "R9 unmapped");
        host_rd(8'hFC, 1'b0, 32'h0, "R9 unmapped top");

        // R11 done while idle
        ctl_finish(1'b0, 8'h11);
        check({31'h0, host_done_irq}, 32'h0, "R11 no irq");
        host_rd(8'h04, 1'b0, 32'h007E5A32, "R11 status");

        // R10/R7 new command without completion pulse
        host_src_id = 8'h11;
        host_wr(8'h00, 32'h00002042);
        check({31'h0, ctl_doorbell}, 32'h1, "R2 second doorbell");
        host_rd(8'h04, 1'b0, 32'h00001121, "R10 error cleared");
        ctl_finish(1'b0, 8'h00);
        check({31'h0, host_done_irq}, 32'h0, "R7 no irq without request");
        host_rd(8'h04, 1'b0, 32'h00001120, "R6 clean done");
        check({31'h0, cmd_overrun}, 32'h1, "R8 sticky");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "scoreboard drained");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule